// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller Bank

This block gathers a bank of external interrupt lines (32 by default) and merges them into two combined interrupt outputs. Each line has its own sensing mode. It can be level-sensitive with either active polarity. It can be edge-sensitive on the rising edge or on the falling edge. It can also fire on any edge. A detected edge is held in a per-line latch until software clears it. Software can also raise any line directly through a soft-assert bit, whatever the external input is doing.

The block has a simple synchronous register port: a write strobe, an address, write data, and combinational read data. Enables and soft-assert bits each have a separate set address and clear address, so no read-modify-write is needed to change one line. Every configuration register can be read back, so its state can be saved and restored. A route register sends each enabled line to one of the two outputs. External inputs pass through a two-flop synchronizer before detection.

Top module: `intc_bank`

## Requirements
- R1: After reset, all enables, soft-assert bits, edge latches and mode/route registers are 0, and both outputs are low.
- R2: A line with level bit = 1 is pending while its synchronized input equals its polarity bit: high when polarity = 1, low when polarity = 0. No edge is latched for it.
- R3: A line with level bit = 0 and any-edge bit = 0 latches an edge event on a rising input when polarity = 1, or on a falling input when polarity = 0. The opposite edge is not latched. The latch stays set after the input returns.
- R4: A line with level bit = 0 and any-edge bit = 1 latches on both rising and falling edges. Its polarity bit has no effect.
- R5: Writing 1s to address 4 sets enables, and writing 1s to address 5 clears them. Zero bits in either write leave those lines unchanged. Reading either address returns the enable vector.
- R6: Writing 1s to address 8 clears those lines' edge latches, and zero bits leave the other latches unchanged. Reading address 8 returns the edge latches.
- R7: Writing 1s to address 6 sets soft-assert bits, and writing 1s to address 7 clears them. A set soft-assert bit makes its line pending regardless of the input. Reading address 6 or 7 returns the soft-assert vector.
- R8: Pending = edge latch OR active level OR soft-assert, and it reads at address 9. Masked = pending AND enable, and it reads at address 10. irq_o is the OR of masked lines whose route bit is 0. irq_route_o is the OR of masked lines whose route bit is 1.
- R9: Level, any-edge, polarity and route registers are written and read back at addresses 0, 1, 2 and 3.
- R10: If a new edge is detected on a line in the same cycle as an edge-clear write to that line, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | N_LINES | Write data |
| rdata | output | N_LINES | Read data for addr (combinational) |
| irq_in | input | N_LINES | Asynchronous external interrupt lines |
| irq_o | output | 1 | Combined interrupt for lines with route bit 0 |
| irq_route_o | output | 1 | Combined interrupt for lines with route bit 1 |

## Verification
Two functions can fall in the same cycle: a new edge being captured in a line's latch and an edge-clear write to that same line. The bench provokes this by counting the synchronizer and edge-detect stages from an input change. It then places the clear write on exactly the clock edge where the latch captures the event. It judges the result by reading the latch afterwards and requiring it to be set. A clear issued with no new edge must still drop the latch.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [3:0] {
        A_LEVEL    = 4'd0,
        A_ANYEDGE  = 4'd1,
        A_POLAR    = 4'd2,
        A_ROUTE    = 4'd3,
        A_EN_SET   = 4'd4,
        A_EN_CLR   = 4'd5,
        A_SW_SET   = 4'd6,
        A_SW_CLR   = 4'd7,
        A_EDGE_CLR = 4'd8,
        A_PENDING  = 4'd9,
        A_MASKED   = 4'd10
    } reg_addr_e;

    localparam int ADDR_W = 4;

    typedef struct packed {
        logic level;
        logic any_edge;
        logic high;
    } line_mode_t;

    function automatic logic edge_hit(line_mode_t m, logic cur, logic old);
        logic rise;
        logic fall;
        rise = cur & ~old;
        fall = ~cur & old;
        if (m.level)
            return 1'b0;
        if (m.any_edge)
            return rise | fall;
        return m.high ? rise : fall;
    endfunction

    function automatic logic level_hit(line_mode_t m, logic cur);
        return m.level & (m.high ? cur : ~cur);
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] old
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            old    <= '0;
        end else begin
            meta_q <= async_in;
            cur    <= meta_q;
            old    <= cur;
        end
    end
endmodule

// File: rtl/intc_detect.sv
module intc_detect
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] old,
    input  logic [N-1:0] level_cfg,
    input  logic [N-1:0] anyedge_cfg,
    input  logic [N-1:0] polar_cfg,
    input  logic [N-1:0] clr,
    output logic [N-1:0] edge_lat,
    output logic [N-1:0] level_act
);
    logic [N-1:0] det;

    for (genvar i = 0; i < N; i++) begin : g_line
        line_mode_t mode;
        assign mode = '{level: level_cfg[i], any_edge: anyedge_cfg[i], high: polar_cfg[i]};
        assign det[i]       = edge_hit(mode, cur[i], old[i]);
        assign level_act[i] = level_hit(mode, cur[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            edge_lat <= '0;
        else
            edge_lat <= (edge_lat & ~clr) | det;
    end

    // R10
    edge_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (det != '0) |=> ((edge_lat & $past(det)) == $past(det)));

    // R6
    edge_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |=> ((edge_lat & $past(clr & ~det)) == '0));
endmodule

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      edge_lat,
    input  logic [N-1:0]      pending,
    input  logic [N-1:0]      masked,
    output logic [N-1:0]      level_cfg,
    output logic [N-1:0]      anyedge_cfg,
    output logic [N-1:0]      polar_cfg,
    output logic [N-1:0]      route_cfg,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      sw_q,
    output logic [N-1:0]      edge_clr,
    output logic [N-1:0]      rdata
);
    logic wr_at [11];

    for (genvar a = 0; a < 11; a++) begin : g_dec
        assign wr_at[a] = wr_en && (addr == ADDR_W'(a));
    end

    assign edge_clr = wr_at[A_EDGE_CLR] ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_cfg   <= '0;
            anyedge_cfg <= '0;
            polar_cfg   <= '0;
            route_cfg   <= '0;
            en_q        <= '0;
            sw_q        <= '0;
        end else begin
            if (wr_at[A_LEVEL])   level_cfg   <= wdata;
            if (wr_at[A_ANYEDGE]) anyedge_cfg <= wdata;
            if (wr_at[A_POLAR])   polar_cfg   <= wdata;
            if (wr_at[A_ROUTE])   route_cfg   <= wdata;
            if (wr_at[A_EN_SET])  en_q <= en_q | wdata;
            if (wr_at[A_EN_CLR])  en_q <= en_q & ~wdata;
            if (wr_at[A_SW_SET])  sw_q <= sw_q | wdata;
            if (wr_at[A_SW_CLR])  sw_q <= sw_q & ~wdata;
        end
    end

    always_comb begin
        unique case (addr)
            A_LEVEL:              rdata = level_cfg;
            A_ANYEDGE:            rdata = anyedge_cfg;
            A_POLAR:              rdata = polar_cfg;
            A_ROUTE:              rdata = route_cfg;
            A_EN_SET, A_EN_CLR:   rdata = en_q;
            A_SW_SET, A_SW_CLR:   rdata = sw_q;
            A_EDGE_CLR:           rdata = edge_lat;
            A_PENDING:            rdata = pending;
            A_MASKED:             rdata = masked;
            default:              rdata = '0;
        endcase
    end

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_at[A_EN_SET] |=> ((en_q & $past(wdata)) == $past(wdata)));

    // R5
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_at[A_EN_CLR] |=> ((en_q & $past(wdata)) == '0));

    // R7
    sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_at[A_SW_CLR] |=> ((sw_q & $past(wdata)) == '0));
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [3:0]         addr,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic               irq_o,
    output logic               irq_route_o
);
    logic [N_LINES-1:0] cur, old;
    logic [N_LINES-1:0] level_cfg, anyedge_cfg, polar_cfg, route_cfg;
    logic [N_LINES-1:0] en_q, sw_q, edge_clr, edge_lat, level_act;
    logic [N_LINES-1:0] pending, masked;

    intc_sync #(.W(N_LINES)) u_sync (
        .clk(clk), .rst(rst), .async_in(irq_in), .cur(cur), .old(old)
    );

    intc_detect #(.N(N_LINES)) u_detect (
        .clk(clk), .rst(rst), .cur(cur), .old(old),
        .level_cfg(level_cfg), .anyedge_cfg(anyedge_cfg), .polar_cfg(polar_cfg),
        .clr(edge_clr), .edge_lat(edge_lat), .level_act(level_act)
    );

    intc_cfg_regs #(.N(N_LINES)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .edge_lat(edge_lat), .pending(pending), .masked(masked),
        .level_cfg(level_cfg), .anyedge_cfg(anyedge_cfg), .polar_cfg(polar_cfg),
        .route_cfg(route_cfg), .en_q(en_q), .sw_q(sw_q),
        .edge_clr(edge_clr), .rdata(rdata)
    );

    assign pending     = edge_lat | level_act | sw_q;
    assign masked      = pending & en_q;
    assign irq_o       = |(masked & ~route_cfg);
    assign irq_route_o = |(masked & route_cfg);

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (!irq_o && !irq_route_o));

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_d && !rst)
            reset_state_chk: assert (en_q == '0 && sw_q == '0 && edge_lat == '0);
    end
endmodule

// File: tb/intc_bank_bench.sv
module intc_bank_bench;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [3:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] irq_in = '0;
    logic         irq_o, irq_route_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    intc_bank #(.N_LINES(N)) u_intc_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .irq_o(irq_o), .irq_route_o(irq_route_o)
    );

    task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        rd(4'd4, v);  chk("R1 enables", v, '0);
        rd(4'd6, v);  chk("R1 soft", v, '0);
        rd(4'd8, v);  chk("R1 edge latches", v, '0);
        rd(4'd0, v);  chk("R1 level cfg", v, '0);
        chk("R1 outputs", {30'd0, irq_o, irq_route_o}, '0);
    endtask

    task automatic t_readback();
        logic [N-1:0] v;
        wr(4'd0, 32'hA5A5_0F0F); rd(4'd0, v); chk("R9 level", v, 32'hA5A5_0F0F);
        wr(4'd1, 32'h1234_5678); rd(4'd1, v); chk("R9 anyedge", v, 32'h1234_5678);
        wr(4'd2, 32'hDEAD_BEEF); rd(4'd2, v); chk("R9 polarity", v, 32'hDEAD_BEEF);
        wr(4'd3, 32'h8000_0001); rd(4'd3, v); chk("R9 route", v, 32'h8000_0001);
        wr(4'd0, '0); wr(4'd1, '0); wr(4'd2, '0); wr(4'd3, '0);
        wr(4'd8, '1);
    endtask

    task automatic t_level();
        logic [N-1:0] v;
        wr(4'd0, 32'h8); wr(4'd2, 32'h8);
        irq_in[3] = 1'b1; settle();
        rd(4'd9, v); chk("R2 active high pending", v, 32'h8);
        irq_in[3] = 1'b0; settle();
        rd(4'd9, v); chk("R2 active high released", v, '0);
        rd(4'd8, v); chk("R2 no edge latched", v, '0);
        wr(4'd2, '0); settle();
        rd(4'd9, v); chk("R2 active low pending", v, 32'h8);
        wr(4'd0, '0); wr(4'd8, '1);
    endtask

    task automatic t_edge();
        logic [N-1:0] v;
        wr(4'd2, 32'h20);
        irq_in[5] = 1'b1; settle(); irq_in[5] = 1'b0; settle();
        rd(4'd8, v); chk("R3 rising latched and held", v, 32'h20);
        wr(4'd8, '1); wr(4'd2, '0);
        irq_in[5] = 1'b1; settle();
        rd(4'd8, v); chk("R3 rising ignored in falling mode", v, '0);
        irq_in[5] = 1'b0; settle();
        rd(4'd8, v); chk("R3 falling latched", v, 32'h20);
        rd(4'd9, v); chk("R8 pending from latch", v, 32'h20);
        wr(4'd8, '1);
    endtask

    task automatic t_anyedge();
        logic [N-1:0] v;
        wr(4'd1, 32'h80); wr(4'd2, 32'h80);
        irq_in[7] = 1'b1; settle();
        rd(4'd8, v); chk("R4 rise latched", v, 32'h80);
        wr(4'd8, 32'h80);
        irq_in[7] = 1'b0; settle();
        rd(4'd8, v); chk("R4 fall latched despite polarity 1", v, 32'h80);
        wr(4'd8, '1); wr(4'd1, '0); wr(4'd2, '0);
    endtask

    task automatic t_soft_enable();
        logic [N-1:0] v;
        wr(4'd6, 32'h200);
        rd(4'd9, v); chk("R7 soft assert pending with input low", v, 32'h200);
        chk("R8 disabled line no irq", {31'd0, irq_o}, '0);
        wr(4'd4, 32'h200);
        rd(4'd10, v); chk("R8 masked", v, 32'h200);
        chk("R8 irq_o high", {31'd0, irq_o}, 1);
        wr(4'd4, '0); rd(4'd4, v); chk("R5 zero set write", v, 32'h200);
        wr(4'd5, 32'h1); rd(4'd5, v); chk("R5 other-bit clear", v, 32'h200);
        wr(4'd3, 32'h200);
        chk("R8 routed output", {30'd0, irq_o, irq_route_o}, 2'b01);
        wr(4'd3, '0);
        wr(4'd5, 32'h200); rd(4'd4, v); chk("R5 clear", v, '0);
        chk("R5 irq low after clear", {31'd0, irq_o}, '0);
        wr(4'd7, 32'h200); rd(4'd6, v); chk("R7 soft clear", v, '0);
    endtask

    task automatic t_clear_race();
        logic [N-1:0] v;
        wr(4'd2, 32'h22);
        irq_in[5] = 1'b1; irq_in[1] = 1'b1; settle();
        wr(4'd8, 32'h1); rd(4'd8, v); chk("R6 zero bits keep latch", v, 32'h22);
        wr(4'd8, 32'h2); rd(4'd8, v); chk("R6 clear one latch", v, 32'h20);
        irq_in[5] = 1'b0; wr(4'd8, '1); settle();
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd8; wdata = 32'h20;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        rd(4'd8, v); chk("R10 edge kept over clear", v, 32'h20);
        wr(4'd8, 32'h20); rd(4'd8, v); chk("R6 plain clear", v, '0);
        irq_in = '0; wr(4'd2, '0); settle(); wr(4'd8, '1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_level();
        t_edge();
        t_anyedge();
        t_soft_enable();
        t_clear_race();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule